// File: doc/BRIEF.md
# Special memory operation ordering interlock

This block is the hazard logic of an in-order core whose pipeline runs F1, F2, D, E, M1, M2, W, U1, U2. The memory ports are reached from different stages. An ordinary load goes to memory at the end of E and gets its data back at the end of M2. Stores and special memory operations wait until W, past the commit point, because a special operation changes memory state and must never be replayed. The two extra stages U1 and U2 keep the two-cycle data latency of a special load. Without an interlock, a load that comes right after a special load would reach memory first.

The block follows the memory-relevant instructions from E to U2. It stalls an ordinary load or store in D until that operation would reach memory after every older special operation, with one idle memory cycle between them. The hold is worked out each cycle from the stage that the youngest older special operation occupies, so a special operation that has already moved ahead causes a shorter hold. A single advance input freezes the whole pipeline. A flush kills every uncommitted instruction up to a chosen depth. The block drives an early issue strobe, a late issue strobe with the operation kind, and the two data-return strobes, each carrying the tag of its instruction.

Top module: `memop_order_interlock`

## Requirements
- R1: A kind 1 (ordinary load) accepted from D gives `early_issue_valid` with its tag in the first advancing cycle in which it sits in E. It gives `load_ret_valid` two advancing cycles later, when it sits in M2.
- R2: Kinds 2 (store), 3 (special load) and 4 (special store) give `late_issue_valid`, with `late_issue_kind` equal to the kind code and the tag, in the advancing cycle in which they sit in W. A kind 3 gives `spec_ret_valid` two advancing cycles later, from U2.
- R3: A kind 1 in D stalls while the youngest older special operation sits in E, M1, M2 or W. From an adjacent special operation the hold is 4 cycles in all, and each cycle of separation shortens it by one. Only kinds 1 and 2 ever stall.
- R4: A kind 2 in D stalls for exactly one cycle when a special operation sits in E, and is not stalled otherwise.
- R5: With no special operation in E through W, `stall_d` is low. This includes the case where special operations sit only in U1 or U2.
- R6: After a late issue of kind 3 or 4, the next cycle carries no ordinary load issue and no store issue.
- R7: `flush` kills D plus the first `flush_depth` stages counted from E: 1 is E, 4 or more is E through W. Killed instructions never issue or return. Once the killed special operations are gone, no stall remains.
- R8: Instructions in U1 and U2 are never killed. A special load in U1 during a flush still returns.
- R9: While `adv` is low, no strobe fires and the pipeline holds, except for instructions a flush removes.
- R10: During reset every output is low.
- R11: Kind codes 0 and 5 to 7 are empty. They never issue, never stall and never cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Pipeline advance; low freezes every stage |
| flush | input | 1 | Kill uncommitted instructions |
| flush_depth | input | FD_W | Number of stages from E killed along with D |
| d_kind | input | 3 | Class of the instruction in D (0 empty, 1 load, 2 store, 3 special load, 4 special store) |
| d_tag | input | TAG_W | Tag of the instruction in D |
| stall_d | output | 1 | Hold D this cycle |
| early_issue_valid | output | 1 | Ordinary load issues to memory |
| early_issue_tag | output | TAG_W | Tag of the early issue |
| late_issue_valid | output | 1 | Store or special operation issues to memory |
| late_issue_kind | output | 3 | Kind code of the late issue |
| late_issue_tag | output | TAG_W | Tag of the late issue |
| load_ret_valid | output | 1 | Ordinary load data returns |
| load_ret_tag | output | TAG_W | Tag of the returning ordinary load |
| spec_ret_valid | output | 1 | Special load data returns |
| spec_ret_tag | output | TAG_W | Tag of the returning special load |

## Verification
The assertions check on every cycle that no ordinary issue follows a special issue in the next cycle, and that a stall appears only for ordinary kinds and only while a special operation sits in E to W. They also check that a frozen pipeline emits nothing, that a flush of E suppresses the early strobe, and that special operations past W survive a freeze. The exact hold lengths cannot be shown by the assertions and come from the bench scenarios: 4, 3, 2, 1 and 0 cycles for loads, 1 and 0 for stores. The same holds for the tag carried to each strobe, for the stall vanishing after a flush, and for a late special load returning through a flush.

// File: rtl/memop_ilk_pkg.sv
package memop_ilk_pkg;

  typedef enum logic [2:0] {
    MK_NONE   = 3'd0,
    MK_LOAD   = 3'd1,
    MK_STORE  = 3'd2,
    MK_SLOAD  = 3'd3,
    MK_SSTORE = 3'd4
  } mem_kind_e;

  typedef struct packed {
    logic      live;
    mem_kind_e kind;
  } slot_t;

  // Codes above the last defined kind are treated as empty slots.
  function automatic mem_kind_e clean_kind(input logic [2:0] raw);
    return (raw > 3'd4) ? MK_NONE : mem_kind_e'(raw);
  endfunction

  function automatic logic is_special(input mem_kind_e k);
    return (k == MK_SLOAD) || (k == MK_SSTORE);
  endfunction

  function automatic logic is_ordinary(input mem_kind_e k);
    return (k == MK_LOAD) || (k == MK_STORE);
  endfunction

  // Load in D vs special at stage index pos (0 = E): the load reaches
  // memory one stall-free cycle from now; the special needs late-pos.
  function automatic int hold_for_load(input int pos, input int late, input int gap);
    return (pos > late) ? 0 : (late - pos + gap);
  endfunction

  // Store in D vs special at pos: both issue at W, so only the gap counts.
  function automatic int hold_for_store(input int pos, input int gap);
    return (gap > pos) ? (gap - pos) : 0;
  endfunction

endpackage

// File: rtl/memop_ilk_kill.sv
module memop_ilk_kill #(
  parameter int NS       = 6,
  parameter int LATE_IDX = 3,
  parameter int FD_W     = 3
) (
  input  logic            flush,
  input  logic [FD_W-1:0] depth,
  output logic            kill_d,
  output logic [NS-1:0]   kill
);
  assign kill_d = flush;

  for (genvar i = 0; i < NS; i++) begin : g_kill
    if (i <= LATE_IDX) begin : g_uncommitted
      assign kill[i] = flush && (depth > FD_W'(i));
    end else begin : g_committed
      assign kill[i] = 1'b0;
    end
  end
endmodule

// File: rtl/memop_ilk_pipe.sv
module memop_ilk_pipe
  import memop_ilk_pkg::*;
#(
  parameter int NS       = 6,
  parameter int TAG_W    = 6,
  parameter int LATE_IDX = 3,
  parameter int MEM_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [NS-1:0]     kill,
  input  slot_t             in_slot,
  input  logic [TAG_W-1:0]  in_tag,
  output slot_t [NS-1:0]    slots,
  output logic [TAG_W-1:0]  tag_early,
  output logic [TAG_W-1:0]  tag_ret,
  output logic [TAG_W-1:0]  tag_late,
  output logic [TAG_W-1:0]  tag_tail
);
  logic [NS-1:0][TAG_W-1:0] tag_q;

  for (genvar i = 0; i < NS; i++) begin : g_stage
    slot_t            nxt;
    logic [TAG_W-1:0] nxt_tag;
    slot_t            q;

    if (i == 0) begin : g_head
      assign nxt     = in_slot;
      assign nxt_tag = in_tag;
    end else begin : g_body
      // A killed older neighbour moves on as a bubble.
      assign nxt     = kill[i-1] ? slot_t'('0) : slots[i-1];
      assign nxt_tag = tag_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q        <= slot_t'('0);
        tag_q[i] <= '0;
      end else if (adv) begin
        q        <= nxt;
        tag_q[i] <= nxt_tag;
      end else if (kill[i]) begin
        q.live   <= 1'b0;
      end
    end

    assign slots[i] = q;
  end

  assign tag_early = tag_q[0];
  assign tag_ret   = tag_q[MEM_LAT];
  assign tag_late  = tag_q[LATE_IDX];
  assign tag_tail  = tag_q[NS-1];
endmodule

// File: rtl/memop_ilk_hazard.sv
module memop_ilk_hazard
  import memop_ilk_pkg::*;
#(
  parameter int NS       = 6,
  parameter int LATE_IDX = 3,
  parameter int GAP      = 1,
  parameter int CW       = 3
) (
  input  slot_t [NS-1:0] slots,
  input  mem_kind_e      d_kind,
  output logic           stall,
  output logic           spec_window,
  output logic           tail_spec
);
  logic [NS-1:0]             spec_at;
  logic [LATE_IDX:0][CW-1:0] need_ld;
  logic [LATE_IDX:0][CW-1:0] need_st;
  logic [CW-1:0]             hold_need;

  for (genvar i = 0; i < NS; i++) begin : g_scan
    assign spec_at[i] = slots[i].live && is_special(slots[i].kind);
    if (i <= LATE_IDX) begin : g_need
      assign need_ld[i] = spec_at[i] ? CW'(hold_for_load(i, LATE_IDX, GAP)) : '0;
      assign need_st[i] = spec_at[i] ? CW'(hold_for_store(i, GAP)) : '0;
    end
  end

  // The largest requirement comes from the youngest older special.
  always_comb begin
    hold_need = '0;
    for (int i = 0; i <= LATE_IDX; i++) begin
      if (d_kind == MK_LOAD && need_ld[i] > hold_need)  hold_need = need_ld[i];
      if (d_kind == MK_STORE && need_st[i] > hold_need) hold_need = need_st[i];
    end
  end

  assign stall       = (hold_need != '0);
  assign spec_window = |spec_at[LATE_IDX:0];
  assign tail_spec   = |spec_at[NS-1:LATE_IDX+1];
endmodule

// File: rtl/memop_ilk_issue.sv
module memop_ilk_issue
  import memop_ilk_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             adv,
  input  slot_t            e_slot,
  input  logic             e_kill,
  input  logic [TAG_W-1:0] e_tag,
  input  slot_t            r_slot,
  input  logic             r_kill,
  input  logic [TAG_W-1:0] r_tag,
  input  slot_t            w_slot,
  input  logic             w_kill,
  input  logic [TAG_W-1:0] w_tag,
  input  slot_t            u_slot,
  input  logic [TAG_W-1:0] u_tag,
  output logic             early_issue_valid,
  output logic [TAG_W-1:0] early_issue_tag,
  output logic             late_issue_valid,
  output logic [2:0]       late_issue_kind,
  output logic [TAG_W-1:0] late_issue_tag,
  output logic             load_ret_valid,
  output logic [TAG_W-1:0] load_ret_tag,
  output logic             spec_ret_valid,
  output logic [TAG_W-1:0] spec_ret_tag
);
  logic w_goes_late;

  assign w_goes_late = (w_slot.kind == MK_STORE) || is_special(w_slot.kind);

  assign early_issue_valid = adv && e_slot.live && !e_kill && (e_slot.kind == MK_LOAD);
  assign early_issue_tag   = e_tag;

  assign late_issue_valid  = adv && w_slot.live && !w_kill && w_goes_late;
  assign late_issue_kind   = late_issue_valid ? w_slot.kind : 3'd0;
  assign late_issue_tag    = w_tag;

  assign load_ret_valid    = adv && r_slot.live && !r_kill && (r_slot.kind == MK_LOAD);
  assign load_ret_tag      = r_tag;

  assign spec_ret_valid    = adv && u_slot.live && (u_slot.kind == MK_SLOAD);
  assign spec_ret_tag      = u_tag;
endmodule

// File: rtl/memop_order_interlock.sv
module memop_order_interlock
  import memop_ilk_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int LATE_IDX = 3,
  parameter int MEM_LAT  = 2,
  parameter int GAP      = 1,
  parameter int FD_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             flush,
  input  logic [FD_W-1:0]  flush_depth,
  input  logic [2:0]       d_kind,
  input  logic [TAG_W-1:0] d_tag,
  output logic             stall_d,
  output logic             early_issue_valid,
  output logic [TAG_W-1:0] early_issue_tag,
  output logic             late_issue_valid,
  output logic [2:0]       late_issue_kind,
  output logic [TAG_W-1:0] late_issue_tag,
  output logic             load_ret_valid,
  output logic [TAG_W-1:0] load_ret_tag,
  output logic             spec_ret_valid,
  output logic [TAG_W-1:0] spec_ret_tag
);
  localparam int NS = LATE_IDX + MEM_LAT + 1;
  localparam int CW = $clog2(LATE_IDX + GAP + 2);

  mem_kind_e        d_kind_c;
  slot_t            entry;
  slot_t [NS-1:0]   slots;
  logic  [NS-1:0]   kill;
  logic             kill_d;
  logic             spec_window;
  logic             tail_spec;
  logic [TAG_W-1:0] tag_early, tag_ret, tag_late, tag_tail;

  assign d_kind_c   = clean_kind(d_kind);
  assign entry.live = (d_kind_c != MK_NONE) && !stall_d && !kill_d;
  assign entry.kind = d_kind_c;

  memop_ilk_kill #(.NS(NS), .LATE_IDX(LATE_IDX), .FD_W(FD_W)) u_kill (
    .flush (flush),
    .depth (flush_depth),
    .kill_d(kill_d),
    .kill  (kill)
  );

  memop_ilk_pipe #(.NS(NS), .TAG_W(TAG_W), .LATE_IDX(LATE_IDX), .MEM_LAT(MEM_LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .kill     (kill),
    .in_slot  (entry),
    .in_tag   (d_tag),
    .slots    (slots),
    .tag_early(tag_early),
    .tag_ret  (tag_ret),
    .tag_late (tag_late),
    .tag_tail (tag_tail)
  );

  memop_ilk_hazard #(.NS(NS), .LATE_IDX(LATE_IDX), .GAP(GAP), .CW(CW)) u_hazard (
    .slots      (slots),
    .d_kind     (d_kind_c),
    .stall      (stall_d),
    .spec_window(spec_window),
    .tail_spec  (tail_spec)
  );

  memop_ilk_issue #(.TAG_W(TAG_W)) u_issue (
    .adv              (adv),
    .e_slot           (slots[0]),
    .e_kill           (kill[0]),
    .e_tag            (tag_early),
    .r_slot           (slots[MEM_LAT]),
    .r_kill           (kill[MEM_LAT]),
    .r_tag            (tag_ret),
    .w_slot           (slots[LATE_IDX]),
    .w_kill           (kill[LATE_IDX]),
    .w_tag            (tag_late),
    .u_slot           (slots[NS-1]),
    .u_tag            (tag_tail),
    .early_issue_valid(early_issue_valid),
    .early_issue_tag  (early_issue_tag),
    .late_issue_valid (late_issue_valid),
    .late_issue_kind  (late_issue_kind),
    .late_issue_tag   (late_issue_tag),
    .load_ret_valid   (load_ret_valid),
    .load_ret_tag     (load_ret_tag),
    .spec_ret_valid   (spec_ret_valid),
    .spec_ret_tag     (spec_ret_tag)
  );
endmodule

// File: rtl/memop_order_checker.sv
module memop_order_checker #(
  parameter int FD_W    = 3,
  parameter int MEM_LAT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adv,
  input logic            flush,
  input logic [FD_W-1:0] flush_depth,
  input logic [2:0]      d_kind,
  input logic            stall_d,
  input logic            early_issue_valid,
  input logic            late_issue_valid,
  input logic [2:0]      late_issue_kind,
  input logic            load_ret_valid,
  input logic            spec_ret_valid,
  input logic            spec_window,
  input logic            tail_spec
);
  assert_idle_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (late_issue_valid && (late_issue_kind == 3'd3 || late_issue_kind == 3'd4))
      |=> !early_issue_valid && !(late_issue_valid && late_issue_kind == 3'd2));

  assert_no_window_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_window |-> !stall_d);

  assert_stall_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_d |-> (d_kind == 3'd1 || d_kind == 3'd2));

  assert_frozen_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> !early_issue_valid && !late_issue_valid && !load_ret_valid && !spec_ret_valid);

  assert_flush_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && flush_depth != '0) |-> !early_issue_valid);

  assert_flush_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && flush_depth > FD_W'(MEM_LAT)) |-> !load_ret_valid);

  assert_tail_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_spec && !adv) |=> tail_spec);
endmodule

bind memop_order_interlock memop_order_checker #(.FD_W(FD_W), .MEM_LAT(MEM_LAT)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .adv              (adv),
  .flush            (flush),
  .flush_depth      (flush_depth),
  .d_kind           (d_kind),
  .stall_d          (stall_d),
  .early_issue_valid(early_issue_valid),
  .late_issue_valid (late_issue_valid),
  .late_issue_kind  (late_issue_kind),
  .load_ret_valid   (load_ret_valid),
  .spec_ret_valid   (spec_ret_valid),
  .spec_window      (spec_window),
  .tail_spec        (tail_spec)
);

// File: tb/memop_order_interlock_test.sv
module memop_order_interlock_test;
  localparam int TW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, adv, flush;
  logic [2:0]    flush_depth, d_kind;
  logic [TW-1:0] d_tag;
  logic          stall_d, early_issue_valid, late_issue_valid, load_ret_valid, spec_ret_valid;
  logic [TW-1:0] early_issue_tag, late_issue_tag, load_ret_tag, spec_ret_tag;
  logic [2:0]    late_issue_kind;

  memop_order_interlock #(.TAG_W(TW)) uut (.*);

  int n_cmp = 0, n_bad = 0;

  // Reference pipeline: index 0 = E ... 5 = U2
  logic          mv[6];
  logic [2:0]    mk[6];
  logic [TW-1:0] mt[6];
  logic          prev_spec_issue = 1'b0;
  logic          s_stall, s_early, s_late, s_sret, s_accept;
  logic [TW-1:0] s_sret_tag;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [2:0] kclean(input logic [2:0] k);
    return (k > 3'd4) ? 3'd0 : k;
  endfunction

  function automatic logic spec_k(input logic [2:0] k);
    return k == 3'd3 || k == 3'd4;
  endfunction

  // Memory-time view: special at stage s reaches memory in 3-s cycles;
  // an ordinary op must arrive at least two cycles after it.
  function automatic int hold_want(input logic [2:0] k);
    int best = 0;
    logic [2:0] kc = kclean(k);
    if (kc != 3'd1 && kc != 3'd2) return 0;
    for (int s = 0; s < 4; s++) begin
      if (mv[s] && spec_k(mk[s])) begin
        int own_t = (kc == 3'd1) ? 1 : 4;
        int w = (3 - s) + 2 - own_t;
        if (w > best) best = w;
      end
    end
    return best;
  endfunction

  function automatic logic mkill(input int s);
    return flush && s <= 3 && s < int'(flush_depth);
  endfunction

  task automatic step(input logic a, input logic f, input logic [2:0] fd,
                      input logic [2:0] k, input logic [TW-1:0] t);
    logic e_exp, l_exp, r_exp, u_exp, st_exp, ord_now;
    logic [2:0] kc;
    @(negedge clk);
    adv = a; flush = f; flush_depth = fd; d_kind = k; d_tag = t;
    #1;
    kc     = kclean(k);
    st_exp = hold_want(k) > 0;
    e_exp  = a && mv[0] && mk[0] == 3'd1 && !mkill(0);
    l_exp  = a && mv[3] && (mk[3] == 3'd2 || spec_k(mk[3])) && !mkill(3);
    r_exp  = a && mv[2] && mk[2] == 3'd1 && !mkill(2);
    u_exp  = a && mv[5] && mk[5] == 3'd3;
    chk("R3/R4/R5/R11 stall_d", stall_d, st_exp);
    chk("R1 early issue", early_issue_valid, e_exp);
    if (e_exp) chk("R1 early tag", early_issue_tag, mt[0]);
    chk("R2 late issue", late_issue_valid, l_exp);
    if (l_exp) begin
      chk("R2 late kind", late_issue_kind, mk[3]);
      chk("R2 late tag", late_issue_tag, mt[3]);
    end
    chk("R1/R7 load return", load_ret_valid, r_exp);
    if (r_exp) chk("R1 return tag", load_ret_tag, mt[2]);
    chk("R2/R8 special return", spec_ret_valid, u_exp);
    if (u_exp) chk("R2 special return tag", spec_ret_tag, mt[5]);
    ord_now = early_issue_valid || (late_issue_valid && late_issue_kind == 3'd2);
    if (prev_spec_issue) chk("R6 idle memory slot", ord_now, 1'b0);
    prev_spec_issue = late_issue_valid && spec_k(late_issue_kind);
    s_stall = stall_d; s_early = early_issue_valid; s_late = late_issue_valid;
    s_sret = spec_ret_valid; s_sret_tag = spec_ret_tag;
    s_accept = kc != 3'd0 && !st_exp && !f;
    if (a) begin
      for (int s = 5; s > 0; s--) begin
        mv[s] = mv[s-1] && !mkill(s-1);
        mk[s] = mk[s-1]; mt[s] = mt[s-1];
      end
      mv[0] = s_accept; mk[0] = kc; mt[0] = t;
    end else begin
      for (int s = 0; s < 6; s++) if (mkill(s)) mv[s] = 1'b0;
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 3'd0, '0);
  endtask

  task automatic pair(input logic [2:0] first, input int g, input logic [2:0] second,
                      input int exp_hold, input string rq);
    int n = 0;
    step(1'b1, 1'b0, 3'd0, first, 6'd1);
    for (int i = 0; i < g; i++) step(1'b1, 1'b0, 3'd0, 3'd0, '0);
    do begin
      step(1'b1, 1'b0, 3'd0, second, 6'd2);
      if (s_stall) n++;
    end while (s_stall && n < 10);
    chk(rq, n, exp_hold);
    drain(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [2:0] k;
    logic [TW-1:0] t;
    void'($urandom(32'd1234));
    for (int s = 0; s < 6; s++) begin mv[s] = 0; mk[s] = 0; mt[s] = 0; end
    rst_n = 0; adv = 1; flush = 0; flush_depth = 0; d_kind = 3'd1; d_tag = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset stall_d", stall_d, 0);
    chk("R10 reset early", early_issue_valid, 0);
    chk("R10 reset late", late_issue_valid, 0);
    chk("R10 reset returns", load_ret_valid | spec_ret_valid, 0);
    rst_n = 1; d_kind = 0;

    // R3: load behind a special load, 0..3 bubbles apart; R5 at 4 apart
    pair(3'd3, 0, 3'd1, 4, "R3 hold adjacent");
    pair(3'd3, 1, 3'd1, 3, "R3 hold one apart");
    pair(3'd4, 2, 3'd1, 2, "R3 hold two apart");
    pair(3'd3, 3, 3'd1, 1, "R3 hold three apart");
    pair(3'd3, 4, 3'd1, 0, "R5 special already past W");
    pair(3'd2, 0, 3'd1, 0, "R5 store is not special");
    // R4: store behind special
    pair(3'd4, 0, 3'd2, 1, "R4 store adjacent");
    pair(3'd3, 1, 3'd2, 0, "R4 store one apart");

    // R7: flush removes the special in E, stall must vanish
    step(1, 0, 0, 3'd3, 6'd7);
    step(1, 1, 3'd1, 3'd1, 6'd8);
    step(1, 0, 0, 3'd1, 6'd8);
    chk("R7 stall cleared after flush", s_stall, 0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin step(1, 0, 0, 0, 0); if (s_late) cnt++; end
    chk("R7 killed special never issues", cnt, 0);

    // R8: special load in U1 survives a frozen full flush
    step(1, 0, 0, 3'd3, 6'd9);
    drain(4);
    step(0, 1, 3'd4, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk("R8 special load returns", s_sret, 1);
    chk("R8 special load tag", s_sret_tag, 6'd9);
    drain(4);

    // R9: freeze with a load in E
    step(1, 0, 0, 3'd1, 6'd5);
    step(0, 0, 0, 0, 0);
    chk("R9 frozen no issue", s_early, 0);
    step(1, 0, 0, 0, 0);
    chk("R9 issue after thaw", s_early, 1);
    drain(4);

    // R11: unknown code behind a special
    step(1, 0, 0, 3'd4, 6'd3);
    step(1, 0, 0, 3'd6, 6'd4);
    chk("R11 unknown kind not stalled", s_stall, 0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin step(1, 0, 0, 0, 0); if (s_late) cnt++; end
    chk("R11 only the special issues late", cnt, 1);

    // Constrained random traffic
    k = 0; t = 0;
    for (int i = 0; i < 4000; i++) begin
      logic a, f;
      logic [2:0] fd;
      logic [31:0] r;
      a  = ($urandom % 8) != 0;
      f  = ($urandom % 40) == 0;
      fd = 3'($urandom % 6);
      if (!(kclean(k) != 0 && !s_accept && !flush)) begin
        r = $urandom % 16;
        k = (r < 4) ? 3'd0 : (r < 8) ? 3'd1 : (r < 10) ? 3'd2 :
            (r < 12) ? 3'd3 : (r < 14) ? 3'd4 : 3'(5 + r % 3);
        t = TW'($urandom);
      end
      step(a, f, fd, k, t);
    end
    drain(8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule